// File: doc/BRIEF.md
# Halfword and Signed Load/Store Unit

This unit executes the halfword and signed-narrow transfer class of a 32-bit load/store instruction set. Each cycle it may be handed one instruction word together with the current N, Z, C and V flags. It checks the encoding and the condition field, reads the base, offset and store-source registers through three combinational read ports, and forms the effective address. The offset is either a register or an 8-bit immediate split across two nibbles of the word. The address is applied before or after the access, as the index mode selects.

One cycle after an instruction is accepted, the unit issues a single-cycle memory request with address, size, direction and store data. In that same cycle it takes the right-justified read data and issues up to two register write requests. One goes to the destination register with the loaded value, extended to the full width. The other goes to the base register with the updated address. Inside a pipeline it sits where the memory stage would call it. It holds no state beyond one stage register and has no back-pressure.

Top module: `hx_xfer_unit`

## Requirements
- R1: An instruction is accepted only when bits 27..25 are 000, bit 7 and bit 4 are 1, and bits 6..5 are not 00. A form with bit 6 = 1 (signed) is accepted only when bit 20 = 1 (load). Any other word produces no memory request and no register write.
- R2: The condition code in bits 31..28 is evaluated against flags[3:0] = {N,Z,C,V}. Codes 0..13 pass as follows: EQ Z, NE !Z, CS C, CC !C, MI N, PL !N, VS V, VC !V, HI C&!Z, LS !C|Z, GE N==V, LT N!=V, GT !Z&(N==V), LE Z|(N!=V). Code 14 always passes and code 15 never passes. A failing condition produces no request and no write.
- R3: With bit 22 = 1 the offset is the zero-extended 8-bit value {bits 11..8, bits 3..0}. With bit 22 = 0 the offset is the value of the register named by bits 3..0.
- R4: With bit 24 = 1 (pre-index) the access address is the base register (named by bits 19..16) plus the offset when bit 23 = 1, or minus it when bit 23 = 0. With bit 24 = 0 the access address is the unmodified base.
- R5: When bit 24 = 0 or bit 21 = 1, the base plus or minus the offset is written to the base register. The offset register is never written.
- R6: Bits 6..5 choose the access: 01 unsigned halfword, 11 signed halfword, 10 signed byte. mem_half is 1 for halfword and 0 for byte. mem_we is the inverse of bit 20.
- R7: A signed halfword load sign-extends rdata[15:0]. A signed byte load uses only rdata[7:0] and sign-extends it. An unsigned halfword load zero-extends rdata[15:0].
- R8: A store drives mem_wdata with the low 16 bits of the register named by bits 15..12.
- R9: On a load with writeback whose destination equals its base, only the loaded value is written and the base write is suppressed.
- R10: The memory request and the register writes of an accepted instruction appear in the cycle after it is presented and last one cycle. After reset, nothing is requested or written until an instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| flags | input | 4 | {N,Z,C,V} condition flags |
| base_idx | output | 4 | Read-port index for the base register |
| base_val | input | 32 | Base register value |
| offs_idx | output | 4 | Read-port index for the offset register |
| offs_val | input | 32 | Offset register value |
| src_idx | output | 4 | Read-port index for the store source |
| src_val | input | 16 | Low half of the store source register |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 store, 0 load |
| mem_half | output | 1 | 1 halfword, 0 byte |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Right-justified load data, same cycle as mem_req |
| ld_we | output | 1 | Destination register write enable |
| ld_idx | output | 4 | Destination register index |
| ld_data | output | 32 | Extended load value |
| wb_we | output | 1 | Base register write enable |
| wb_idx | output | 4 | Base register index |
| wb_data | output | 32 | Updated base address |

## Verification
The bench targets post-indexed transfers. A design that applies the offset before the access there shows the wrong address, and one that writes the offset register instead of the adjusted base shows the wrong writeback. Signed byte loads are driven with memory data whose upper byte disagrees with bit 7, so a design that keeps the upper byte or zero-extends returns a visibly different value. A load whose destination equals its base, with writeback, catches a design that lets the base write collide with or override the loaded value. Neighbouring encodings (bits 6..5 = 00, signed stores, wrong top opcode bits) and the never-code 15 must leave every output idle. A randomized stream with random flags exercises all sixteen condition codes.

// File: rtl/hx_pkg.sv
package hx_pkg;
  localparam int unsigned HX_XLEN = 32;
  localparam int unsigned HX_RIDX = 4;
  localparam int unsigned HX_HALF = 16;
  localparam int unsigned HX_BYTE = 8;
  localparam int unsigned HX_IMM  = 8;
  localparam int unsigned HX_NFLG = 4;

  typedef logic [HX_XLEN-1:0] word_t;
  typedef logic [HX_HALF-1:0] half_t;
  typedef logic [HX_RIDX-1:0] ridx_t;

  typedef struct packed {
    logic              load;
    logic              sgn;
    logic              half;
    logic              pre;
    logic              up;
    logic              use_imm;
    logic              wbk;
    ridx_t             rn;
    ridx_t             rd;
    ridx_t             rm;
    logic [HX_IMM-1:0] imm8;
  } hx_op_t;

  typedef struct packed {
    word_t addr;
    word_t nbase;
    half_t sdata;
    logic  load;
    logic  half;
    logic  sgn;
    logic  wb;
    ridx_t rd;
    ridx_t rn;
  } hx_stage_t;

  // flags = {N,Z,C,V}
  function automatic logic hx_cond_true(input logic [3:0] code, input logic [HX_NFLG-1:0] flags);
    logic n, z, c, v;
    {n, z, c, v} = flags;
    case (code)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic word_t hx_offset_apply(input word_t base, input word_t off, input logic up);
    return up ? (base + off) : (base - off);
  endfunction

  function automatic word_t hx_extend(input half_t raw, input logic half, input logic sgn);
    if (half)
      return sgn ? {{(HX_XLEN-HX_HALF){raw[HX_HALF-1]}}, raw}
                 : {{(HX_XLEN-HX_HALF){1'b0}}, raw};
    return sgn ? {{(HX_XLEN-HX_BYTE){raw[HX_BYTE-1]}}, raw[HX_BYTE-1:0]}
               : {{(HX_XLEN-HX_BYTE){1'b0}}, raw[HX_BYTE-1:0]};
  endfunction
endpackage

// File: rtl/hx_decode.sv
module hx_decode
  import hx_pkg::*;
(
  input  word_t      instr,
  output hx_op_t     op,
  output logic [3:0] cond,
  output logic       hit
);
  always_comb begin
    op.pre     = instr[24];
    op.up      = instr[23];
    op.use_imm = instr[22];
    op.wbk     = instr[21];
    op.load    = instr[20];
    op.rn      = instr[19:16];
    op.rd      = instr[15:12];
    op.sgn     = instr[6];
    op.half    = instr[5];
    op.rm      = instr[3:0];
    op.imm8    = {instr[11:8], instr[3:0]};
    cond       = instr[31:28];
  end

  // class match: 000 opcode group, 1xx1 marker, not the 00 neighbour, signed only on loads
  assign hit = (instr[27:25] == 3'b000) && instr[7] && instr[4] &&
               (instr[6:5] != 2'b00) && (!instr[6] || instr[20]);
endmodule

// File: rtl/hx_cond.sv
module hx_cond
  import hx_pkg::*;
(
  input  logic [3:0]         code,
  input  logic [HX_NFLG-1:0] flags,
  output logic               pass
);
  assign pass = hx_cond_true(code, flags);
endmodule

// File: rtl/hx_agen.sv
module hx_agen
  import hx_pkg::*;
(
  input  word_t base,
  input  word_t off,
  input  logic  up,
  input  logic  pre,
  output word_t addr,
  output word_t nbase
);
  assign nbase = hx_offset_apply(base, off, up);
  assign addr  = pre ? nbase : base;
endmodule

// File: rtl/hx_xfer_unit.sv
module hx_xfer_unit
  import hx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [HX_XLEN-1:0] instr,
  input  logic [HX_NFLG-1:0] flags,
  output logic [HX_RIDX-1:0] base_idx,
  input  logic [HX_XLEN-1:0] base_val,
  output logic [HX_RIDX-1:0] offs_idx,
  input  logic [HX_XLEN-1:0] offs_val,
  output logic [HX_RIDX-1:0] src_idx,
  input  logic [HX_HALF-1:0] src_val,
  output logic               mem_req,
  output logic               mem_we,
  output logic               mem_half,
  output logic [HX_XLEN-1:0] mem_addr,
  output logic [HX_HALF-1:0] mem_wdata,
  input  logic [HX_HALF-1:0] mem_rdata,
  output logic               ld_we,
  output logic [HX_RIDX-1:0] ld_idx,
  output logic [HX_XLEN-1:0] ld_data,
  output logic               wb_we,
  output logic [HX_RIDX-1:0] wb_idx,
  output logic [HX_XLEN-1:0] wb_data
);
  hx_op_t     op;
  logic [3:0] cond_code;
  logic       class_hit;
  logic       cond_pass;
  word_t      offset;
  word_t      acc_addr;
  word_t      new_base;
  logic       acc_fire;
  logic       wb_clash;
  logic       stg_v;
  hx_stage_t  stg;

  hx_decode u_dec (.instr(instr), .op(op), .cond(cond_code), .hit(class_hit));
  hx_cond   u_cnd (.code(cond_code), .flags(flags), .pass(cond_pass));

  assign base_idx = op.rn;
  assign offs_idx = op.rm;
  assign src_idx  = op.rd;
  assign offset   = op.use_imm ? {{(HX_XLEN-HX_IMM){1'b0}}, op.imm8} : offs_val;

  hx_agen u_agn (
    .base(base_val), .off(offset), .up(op.up), .pre(op.pre),
    .addr(acc_addr), .nbase(new_base)
  );

  assign acc_fire = instr_valid && class_hit && cond_pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v <= 1'b0;
      stg   <= '0;
    end else begin
      stg_v <= acc_fire;
      if (acc_fire) begin
        stg.addr  <= acc_addr;
        stg.nbase <= new_base;
        stg.sdata <= src_val;
        stg.load  <= op.load;
        stg.half  <= op.half;
        stg.sgn   <= op.sgn;
        stg.wb    <= !op.pre || op.wbk;
        stg.rd    <= op.rd;
        stg.rn    <= op.rn;
      end
    end
  end

  assign wb_clash  = stg.load && (stg.rd == stg.rn);

  assign mem_req   = stg_v;
  assign mem_we    = stg_v && !stg.load;
  assign mem_half  = stg.half;
  assign mem_addr  = stg.addr;
  assign mem_wdata = stg.sdata;

  assign ld_we     = stg_v && stg.load;
  assign ld_idx    = stg.rd;
  assign ld_data   = hx_extend(mem_rdata, stg.half, stg.sgn);

  assign wb_we     = stg_v && stg.wb && !wb_clash;
  assign wb_idx    = stg.rn;
  assign wb_data   = stg.nbase;

  // R10
  req_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(acc_fire));

  // R2
  never_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[31:28] == 4'hF) |=> !mem_req);

  // R9
  no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_we && wb_we && ld_idx == wb_idx));

  // R6
  store_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !ld_we);

  // R7
  sbyte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && stg.sgn && !mem_half) |-> (ld_data[HX_XLEN-1:HX_BYTE] == {(HX_XLEN-HX_BYTE){mem_rdata[HX_BYTE-1]}}));

  // R5
  wb_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> mem_req);
endmodule

// File: tb/tb_hx_xfer_unit.sv
module tb_hx_xfer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [3:0]  flags = '0;
  logic [3:0]  base_idx, offs_idx, src_idx;
  logic [31:0] base_val, offs_val, src_full;
  logic [15:0] src_val;
  logic        mem_req, mem_we, mem_half;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        ld_we, wb_we;
  logic [3:0]  ld_idx, wb_idx;
  logic [31:0] ld_data, wb_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] rv(input logic [3:0] i);
    return 32'h2000_0000 + ({28'd0, i} << 12) + {28'd0, i} * 32'h37;
  endfunction

  function automatic logic [15:0] pat(input logic [31:0] a);
    return a[15:0] ^ {a[7:0], a[15:8]} ^ 16'h8E5A;
  endfunction

  assign base_val  = rv(base_idx);
  assign offs_val  = rv(offs_idx);
  assign src_full  = rv(src_idx);
  assign src_val   = src_full[15:0];
  assign mem_rdata = pat(mem_addr);

  hx_xfer_unit dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr), .flags(flags),
    .base_idx(base_idx), .base_val(base_val), .offs_idx(offs_idx), .offs_val(offs_val),
    .src_idx(src_idx), .src_val(src_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  typedef struct {
    logic        req, we, half, ldwe, wbwe;
    logic [31:0] addr, lddata, wbdata;
    logic [15:0] wdata;
    logic [3:0]  ldidx, wbidx;
    string       tag;
  } exp_t;

  exp_t scb[$];

  function automatic logic cpass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v, r;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c[3:1])
      3'd0: r = z;
      3'd1: r = cy;
      3'd2: r = n;
      3'd3: r = v;
      3'd4: r = cy & !z;
      3'd5: r = (n == v);
      3'd6: r = !z & (n == v);
      default: r = 1'b1;
    endcase
    if (c == 4'd15) return 1'b0;
    if (c == 4'd14) return 1'b1;
    return r ^ c[0];
  endfunction

  function automatic exp_t predict(input logic [31:0] w, input logic [3:0] f, input string tag);
    exp_t e;
    logic ok;
    logic [31:0] base, off, moved;
    logic [15:0] raw;
    e = '{req: 0, we: 0, half: 0, ldwe: 0, wbwe: 0, addr: 0, lddata: 0, wbdata: 0,
          wdata: 0, ldidx: 0, wbidx: 0, tag: tag};
    ok = (w[27:25] == 3'b000) && w[7] && w[4] && (w[6:5] != 2'b00) && !(w[6] && !w[20]);
    if (!(ok && cpass(w[31:28], f))) return e;
    base  = rv(w[19:16]);
    off   = w[22] ? {24'd0, w[11:8], w[3:0]} : rv(w[3:0]);
    moved = w[23] ? base + off : base - off;
    e.req  = 1'b1;
    e.we   = !w[20];
    e.half = w[5];
    e.addr = w[24] ? moved : base;
    e.wdata = rv(w[15:12]) & 32'h0000_FFFF;
    raw = pat(e.addr);
    e.ldwe  = w[20];
    e.ldidx = w[15:12];
    if (w[6:5] == 2'b10)      e.lddata = {{24{raw[7]}}, raw[7:0]};
    else if (w[6:5] == 2'b11) e.lddata = {{16{raw[15]}}, raw};
    else                      e.lddata = {16'd0, raw};
    e.wbidx  = w[19:16];
    e.wbdata = moved;
    e.wbwe   = (!w[24] || w[21]) && !(w[20] && w[15:12] == w[19:16]);
    return e;
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] c, input logic p, input logic u,
                                     input logic i, input logic wb, input logic l,
                                     input logic [3:0] rn, input logic [3:0] rd,
                                     input logic [3:0] hi, input logic [1:0] sh,
                                     input logic [3:0] lo);
    return {c, 3'b000, p, u, i, wb, l, rn, rd, hi, 1'b1, sh, 1'b1, lo};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [3:0] f, input string tag);
    @(negedge clk);
    instr_valid = 1'b1;
    instr = w;
    flags = f;
    scb.push_back(predict(w, f, tag));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      instr_valid = 1'b0;
      instr = $urandom;
      scb.push_back(predict(32'h0, 4'h0, "R10"));
    end
  endtask

  initial begin : monitor
    exp_t e;
    logic bad;
    forever begin
      @(posedge clk);
      #2;
      if (scb.size() > 0) begin
        e = scb.pop_front();
        bad = (mem_req !== e.req) || (ld_we !== e.ldwe) || (wb_we !== e.wbwe);
        if (e.req)  bad = bad || (mem_addr !== e.addr) || (mem_we !== e.we) || (mem_half !== e.half);
        if (e.we)   bad = bad || (mem_wdata !== e.wdata);
        if (e.ldwe) bad = bad || (ld_idx !== e.ldidx) || (ld_data !== e.lddata);
        if (e.wbwe) bad = bad || (wb_idx !== e.wbidx) || (wb_data !== e.wbdata);
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL %s: act req=%b we=%b half=%b addr=%h wd=%h ld=%b/%0d/%h wb=%b/%0d/%h exp req=%b we=%b half=%b addr=%h wd=%h ld=%b/%0d/%h wb=%b/%0d/%h",
            e.tag, mem_req, mem_we, mem_half, mem_addr, mem_wdata, ld_we, ld_idx, ld_data,
            wb_we, wb_idx, wb_data, e.req, e.we, e.half, e.addr, e.wdata, e.ldwe, e.ldidx,
            e.lddata, e.wbwe, e.wbidx, e.wbdata);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired: act running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    checks++;
    if (mem_req !== 1'b0 || ld_we !== 1'b0 || wb_we !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: act req=%b ld=%b wb=%b exp 0 0 0", mem_req, ld_we, wb_we);
    end

    // R3 R4 pre-index up, split immediate 0x14, unsigned half load, no writeback
    issue(mk(4'hE, 1, 1, 1, 0, 1, 4'd2, 4'd3, 4'h1, 2'b01, 4'h4), 4'h0, "R3");
    // R4 R5 pre-index down, register offset, writeback
    issue(mk(4'hE, 1, 0, 0, 1, 1, 4'd4, 4'd5, 4'h0, 2'b01, 4'd6), 4'h0, "R5");
    // R5 R8 post-index store, immediate 0x2C: address is unmodified base
    issue(mk(4'hE, 0, 1, 1, 0, 0, 4'd7, 4'd8, 4'h2, 2'b01, 4'hC), 4'h0, "R8");
    // R7 signed byte loads at several addresses
    issue(mk(4'hE, 1, 1, 1, 0, 1, 4'd1, 4'd9, 4'h0, 2'b10, 4'h3), 4'h0, "R7");
    issue(mk(4'hE, 1, 0, 1, 0, 1, 4'd9, 4'd2, 4'hF, 2'b10, 4'hF), 4'h0, "R7");
    // R7 signed half load, post-index register offset
    issue(mk(4'hE, 0, 0, 0, 0, 1, 4'd10, 4'd11, 4'h0, 2'b11, 4'd12), 4'h0, "R7");
    // R6 store halfword with writeback
    issue(mk(4'hE, 1, 1, 0, 1, 0, 4'd3, 4'd14, 4'h0, 2'b01, 4'd1), 4'h0, "R6");
    // R9 load, destination equals base, writeback
    issue(mk(4'hE, 1, 1, 1, 1, 1, 4'd5, 4'd5, 4'h0, 2'b11, 4'h8), 4'h0, "R9");
    issue(mk(4'hE, 0, 1, 1, 0, 1, 4'd6, 4'd6, 4'h1, 2'b01, 4'h0), 4'h0, "R9");
    // R2 never code, and EQ with Z clear then set
    issue(mk(4'hF, 1, 1, 1, 0, 1, 4'd2, 4'd3, 4'h0, 2'b01, 4'h2), 4'hF, "R2");
    issue(mk(4'h0, 1, 1, 1, 0, 1, 4'd2, 4'd3, 4'h0, 2'b01, 4'h2), 4'h0, "R2");
    issue(mk(4'h0, 1, 1, 1, 0, 1, 4'd2, 4'd3, 4'h0, 2'b01, 4'h2), 4'h4, "R2");
    // R1 neighbour encodings produce nothing
    issue(mk(4'hE, 1, 1, 1, 0, 1, 4'd2, 4'd3, 4'h0, 2'b00, 4'h2), 4'h0, "R1");
    issue(mk(4'hE, 1, 1, 1, 0, 0, 4'd2, 4'd3, 4'h0, 2'b11, 4'h2), 4'h0, "R1");
    issue(mk(4'hE, 1, 1, 1, 0, 1, 4'd2, 4'd3, 4'h0, 2'b01, 4'h2) | 32'h0200_0000, 4'h0, "R1");
    idle(2);
    // R10 back-to-back acceptance
    for (int k = 0; k < 4; k++)
      issue(mk(4'hE, k[0], 1, 1, 1, k[1], 4'(k + 1), 4'(k + 8), 4'(k), 2'b01, 4'(k * 3)), 4'h0, "R10");
    idle(1);
    // R4 randomized stream across condition codes and forms
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      w = $urandom;
      w[27:25] = 3'b000;
      w[7] = 1'b1;
      w[4] = 1'b1;
      issue(w, 4'($urandom), "R4");
      if (k % 7 == 0) idle(1);
    end
    idle(3);
    while (scb.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule